// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block collects thirteen classes of controller events into one 32-bit event word and turns them into thirteen dedicated interrupt lines. Internal logic raises an event by pulsing one bit of a set vector; software acknowledges events by writing ones to the event word, and it chooses which events may interrupt by writing a separate enable word. A line is asserted while its event is pending and enabled.

Software reaches both words through a simple register port: the event word at offset 0x004 and the enable word at offset 0x008. Each output line is held in a flop that loads only when the masked state for that line differs from what is currently driven. A companion strobe per line marks the cycle in which that line took a new value, so a downstream controller can act on edges alone.

Top module: `evt_irq_aggr`

## Requirements
- R1: While reset is low at a clock edge, the event word, the enable word, all interrupt lines and all update strobes become zero.
- R2: A write to offset 0x004 clears each event bit whose written bit is 1 and leaves event bits written as 0 unchanged.
- R3: Set input `evt_set[i]` raises the event bit at word position P(i), where P for i = 0..12 is 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30; word bits 18..0 always read as zero.
- R4: When a set pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x008 replaces all 32 bits of the enable word, and a read of 0x008 returns exactly the written value.
- R6: `irq_line[i]` equals event bit P(i) AND enable bit P(i) as they stood one clock earlier.
- R7: `irq_upd[i]` is 1 for exactly the cycle in which `irq_line[i]` took a new value, and 0 in every other cycle.
- R8: A write to any offset other than 0x004 or 0x008 changes neither word, and a read of such an offset returns zero.
- R9: Reads are combinational: `reg_rdata` reflects the addressed word as it stands in the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| evt_set | input | 13 | One-cycle event set pulses, indexed by line |
| irq_line | output | 13 | Interrupt lines, index 0 to 12 |
| irq_upd | output | 13 | One-cycle strobe per line marking a new line value |

## Verification
A write or set pulse presented before clock edge k is visible on `reg_rdata` right after edge k, while the matching `irq_line` bit and `irq_upd` strobe appear after edge k+1 and the strobe is gone after edge k+2. The bench drives all inputs on falling edges, reads registers one nanosecond after the falling edge that follows the write, and waits exactly one further falling edge for each line and strobe check, and one more to confirm the strobe has dropped. Every line is swept one at a time through set, enable and clear, with the expected line index and word position taken from an independent table in the bench.

// File: rtl/evt_irq_pkg.sv
// Package: shared constants and the fixed line-to-bit assignment of the
// masked event interrupt aggregator.
// Assumes: event word is WORD_W = 32 bits; the line order is a fixed
// sequence that does not follow bit order.
package evt_irq_pkg;

    localparam int NUM_LINES = 13;
    localparam int WORD_W    = 32;

    // Word position of the event bit that feeds interrupt line idx.
    function automatic int line_bit(input int idx);
        case (idx)
            0:       return 27;
            1:       return 26;
            2:       return 19;
            3:       return 20;
            4:       return 25;
            5:       return 24;
            6:       return 23;
            7:       return 21;
            8:       return 31;
            9:       return 28;
            10:      return 22;
            11:      return 29;
            12:      return 30;
            default: return 0;
        endcase
    endfunction

    // All word positions that carry a defined event bit.
    function automatic logic [WORD_W-1:0] defined_bits();
        logic [WORD_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            acc[line_bit(i)] = 1'b1;
        end
        return acc;
    endfunction

endpackage

// File: rtl/evt_store.sv
// Module: event store.
// Holds one pending flag per interrupt line, in line order. Flags are set by
// one-cycle pulses and cleared by a write-one-to-clear vector.
// Assumes: clr_i is already gathered into line order; a set in the same
// cycle as a clear of the same flag wins.
module evt_store #(
    parameter int NL = evt_irq_pkg::NUM_LINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] set_i,
    input  logic          clr_en_i,
    input  logic [NL-1:0] clr_i,
    output logic [NL-1:0] evt_o
);

    logic [NL-1:0] evt_q;
    logic [NL-1:0] clr_eff;

    // Qualify the clear vector with the write strobe.
    always_comb begin
        clr_eff = clr_en_i ? clr_i : '0;
    end

    // Update pending flags: clear first, then apply sets so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_q & ~clr_eff) | set_i;
        end
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/mask_store.sv
// Module: enable word store.
// A plain WORD_W-bit register replaced in full on each write.
// Assumes: all bits are kept, including those with no event behind them,
// so software reads back what it wrote.
module mask_store #(
    parameter int WORD_W = evt_irq_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] mask_o
);

    logic [WORD_W-1:0] mask_q;

    // Load the whole word on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we_i) begin
            mask_q <= wdata_i;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/line_driver.sv
// Module: interrupt line driver.
// Compares the masked active vector with the value currently driven and
// loads only the lines that differ; raises a one-cycle strobe for each line
// that took a new value.
// Assumes: active_i is combinational from the registers, so lines follow
// register changes by one clock.
module line_driver #(
    parameter int NL = evt_irq_pkg::NUM_LINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] active_i,
    output logic [NL-1:0] line_o,
    output logic [NL-1:0] upd_o
);

    logic [NL-1:0] line_q;
    logic [NL-1:0] upd_q;
    logic [NL-1:0] differs;

    // Lines whose wanted value is not the one being driven.
    always_comb begin
        differs = active_i ^ line_q;
    end

    for (genvar i = 0; i < NL; i++) begin : g_line
        // Per-line flop: load only on a difference, strobe that cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q[i] <= 1'b0;
                upd_q[i]  <= 1'b0;
            end else begin
                upd_q[i] <= differs[i];
                if (differs[i]) begin
                    line_q[i] <= active_i[i];
                end
            end
        end
    end

    assign line_o = line_q;
    assign upd_o  = upd_q;

endmodule

// File: rtl/evt_irq_aggr.sv
// Module: masked event interrupt aggregator (top).
// Decodes the register port, gathers write data into line order for the
// clear, scatters pending flags into the 32-bit event word for reads,
// masks pending flags with the enable word and hands the result to the
// line driver.
// Assumes: register reads are combinational and side-effect free; writes
// to unknown offsets are dropped.
module evt_irq_aggr #(
    parameter int                ADDR_W  = 10,
    parameter int                WORD_W  = evt_irq_pkg::WORD_W,
    parameter logic [ADDR_W-1:0] EVT_OFF = 10'h004,
    parameter logic [ADDR_W-1:0] MSK_OFF = 10'h008
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr_en,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [WORD_W-1:0]                reg_wdata,
    output logic [WORD_W-1:0]                reg_rdata,
    input  logic [evt_irq_pkg::NUM_LINES-1:0] evt_set,
    output logic [evt_irq_pkg::NUM_LINES-1:0] irq_line,
    output logic [evt_irq_pkg::NUM_LINES-1:0] irq_upd
);

    localparam int NL = evt_irq_pkg::NUM_LINES;

    logic          hit_evt;
    logic          hit_msk;
    logic [NL-1:0] clr_vec;
    logic [NL-1:0] evt_q;
    logic [NL-1:0] active;
    logic [WORD_W-1:0] mask_q;
    logic [WORD_W-1:0] evt_word;

    // Address decode for the two registers.
    always_comb begin
        hit_evt = (reg_addr == EVT_OFF);
        hit_msk = (reg_addr == MSK_OFF);
    end

    for (genvar i = 0; i < NL; i++) begin : g_gather
        localparam int B = evt_irq_pkg::line_bit(i);
        // Pick this line's clear bit and build its masked active value.
        assign clr_vec[i] = reg_wdata[B];
        assign active[i]  = evt_q[i] & mask_q[B];
    end

    // Scatter pending flags to their word positions; other bits stay zero.
    always_comb begin
        evt_word = '0;
        for (int i = 0; i < NL; i++) begin
            evt_word[evt_irq_pkg::line_bit(i)] = evt_q[i];
        end
    end

    // Read multiplexer; unknown offsets read zero.
    always_comb begin
        if (hit_evt) begin
            reg_rdata = evt_word;
        end else if (hit_msk) begin
            reg_rdata = mask_q;
        end else begin
            reg_rdata = '0;
        end
    end

    evt_store #(.NL(NL)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_set),
        .clr_en_i (reg_wr_en & hit_evt),
        .clr_i    (clr_vec),
        .evt_o    (evt_q)
    );

    mask_store #(.WORD_W(WORD_W)) u_msk (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_wr_en & hit_msk),
        .wdata_i (reg_wdata),
        .mask_o  (mask_q)
    );

    line_driver #(.NL(NL)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .line_o   (irq_line),
        .upd_o    (irq_upd)
    );

endmodule

// File: rtl/evt_irq_aggr_chk.sv
// Module: assertion checker for the aggregator, bound to the top.
// Assumes: reset is held low for at least two clocks at start.
module evt_irq_aggr_chk #(
    parameter int                ADDR_W  = 10,
    parameter int                WORD_W  = 32,
    parameter logic [ADDR_W-1:0] EVT_OFF = 10'h004,
    parameter logic [ADDR_W-1:0] MSK_OFF = 10'h008,
    parameter int                NL      = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] wdata,
    input logic [WORD_W-1:0] rdata,
    input logic [NL-1:0]     set,
    input logic [NL-1:0]     evt,
    input logic [WORD_W-1:0] msk,
    input logic [NL-1:0]     line,
    input logic [NL-1:0]     upd
);

    localparam logic [WORD_W-1:0] DEF = evt_irq_pkg::defined_bits();

    // Gather a word into line order.
    function automatic logic [NL-1:0] pick(input logic [WORD_W-1:0] w);
        logic [NL-1:0] r;
        for (int i = 0; i < NL; i++) r[i] = w[evt_irq_pkg::line_bit(i)];
        return r;
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (evt == '0 && msk == '0 && line == '0 && upd == '0));

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == EVT_OFF) |=> ((evt & pick($past(wdata)) & ~$past(set)) == '0));

    // R3
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == EVT_OFF) |-> ((rdata & ~DEF) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((evt & $past(set)) == $past(set)));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MSK_OFF) |=> (msk == $past(wdata)));

    // R6
    line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line == $past(evt & pick(msk)));

    // R7
    upd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd == (line ^ $past(line)));

    // R8
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != EVT_OFF && addr != MSK_OFF)
        |=> ($stable(msk) && evt == ($past(evt) | $past(set))));

endmodule

bind evt_irq_aggr evt_irq_aggr_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .EVT_OFF(EVT_OFF),
    .MSK_OFF(MSK_OFF),
    .NL     (evt_irq_pkg::NUM_LINES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .set   (evt_set),
    .evt   (evt_q),
    .msk   (mask_q),
    .line  (irq_line),
    .upd   (irq_upd)
);

// File: tb/evt_irq_aggr_tb.sv
module evt_irq_aggr_tb;

    localparam int NL = 13;
    localparam logic [9:0] A_EVT = 10'h004;
    localparam logic [9:0] A_MSK = 10'h008;
    localparam logic [31:0] DEFW = 32'hFFF8_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NL-1:0] set_v = '0;
    logic [NL-1:0] irq;
    logic [NL-1:0] upd;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int pos [NL] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

    always #4 clk = ~clk;

    evt_irq_aggr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .evt_set(set_v),
        .irq_line(irq), .irq_upd(upd)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [NL-1:0] s);
        set_v = s;
        @(negedge clk);
        set_v = '0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [NL-1:0] lines_of(input logic [31:0] w);
        logic [NL-1:0] r;
        for (int i = 0; i < NL; i++) r[i] = w[pos[i]];
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NL-1:0] exp_l;
        repeat (5) @(negedge clk);
        // R1: reset state
        rd(A_EVT, v); chk("R1 event", v, 0);
        rd(A_MSK, v); chk("R1 mask", v, 0);
        chk("R1 lines", 32'(irq), 0);
        chk("R1 strobes", 32'(upd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Per-line sweep: R3, R6, R7, R2
        for (int i = 0; i < NL; i++) begin
            pulse(NL'(1) << i);
            rd(A_EVT, v); chk($sformatf("R3 set line %0d", i), v, 32'(1) << pos[i]);
            @(negedge clk);
            chk($sformatf("R6 masked line %0d", i), 32'(irq), 0);
            chk($sformatf("R7 no strobe line %0d", i), 32'(upd), 0);
            wr(A_MSK, 32'(1) << pos[i]);
            @(negedge clk);
            chk($sformatf("R6 enabled line %0d", i), 32'(irq), 32'(1) << i);
            chk($sformatf("R7 rise strobe line %0d", i), 32'(upd), 32'(1) << i);
            @(negedge clk);
            chk($sformatf("R7 strobe drop line %0d", i), 32'(upd), 0);
            wr(A_EVT, 32'(1) << pos[i]);
            rd(A_EVT, v); chk($sformatf("R2 clear line %0d", i), v, 0);
            @(negedge clk);
            chk($sformatf("R6 cleared line %0d", i), 32'(irq), 0);
            chk($sformatf("R7 fall strobe line %0d", i), 32'(upd), 32'(1) << i);
            wr(A_MSK, 0);
        end

        // R2 partial clear, R3 undefined bits zero
        pulse('1);
        rd(A_EVT, v); chk("R3 all defined", v, DEFW);
        wr(A_EVT, 32'h0F00_0000);
        rd(A_EVT, v); chk("R2 partial clear", v, DEFW & ~32'h0F00_0000);
        wr(A_EVT, 32'h0000_0000);
        rd(A_EVT, v); chk("R2 zero write no effect", v, DEFW & ~32'h0F00_0000);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, v); chk("R2 full clear", v, 0);

        // R4 set beats clear
        pulse(NL'(3));
        set_v = NL'(1); wr_en = 1'b1; addr = A_EVT; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        set_v = '0; wr_en = 1'b0;
        rd(A_EVT, v); chk("R4 set wins", v, 32'(1) << pos[0]);
        wr(A_EVT, 32'hFFFF_FFFF);

        // R5 mask read-back
        wr(A_MSK, 32'hFFFF_FFFF); rd(A_MSK, v); chk("R5 ones", v, 32'hFFFF_FFFF);
        wr(A_MSK, 32'h1234_5678); rd(A_MSK, v); chk("R5 pattern", v, 32'h1234_5678);
        wr(A_MSK, 32'h0000_0000); rd(A_MSK, v); chk("R5 zero", v, 0);

        // R6 all lines, then a mixed mask
        pulse('1);
        wr(A_MSK, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R6 all lines", 32'(irq), 32'h1FFF);
        chk("R7 all strobes", 32'(upd), 32'h1FFF);
        wr(A_MSK, 32'hA5A5_A5A5);
        exp_l = lines_of(32'hA5A5_A5A5);
        @(negedge clk);
        chk("R6 mixed mask", 32'(irq), 32'(exp_l));
        chk("R7 mixed strobes", 32'(upd), 32'(exp_l ^ 13'h1FFF));

        // R8 unknown offsets, R9 combinational read
        wr(10'h00C, 32'hFFFF_FFFF);
        rd(A_MSK, v); chk("R8 mask kept", v, 32'hA5A5_A5A5);
        rd(A_EVT, v); chk("R8 events kept", v, DEFW);
        rd(10'h00C, v); chk("R8 unknown read", v, 0);
        rd(10'h000, v); chk("R8 offset zero read", v, 0);
        addr = A_MSK; #1; chk("R9 mux to mask", rdata, 32'hA5A5_A5A5);
        addr = A_EVT; #1; chk("R9 mux to event", rdata, DEFW);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rd(A_EVT, v); chk("R1 event after reset", v, 0);
        rd(A_MSK, v); chk("R1 mask after reset", v, 0);
        chk("R1 lines after reset", 32'(irq), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule